// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes a 16-bit IEEE-754 binary16 code and produces the binary32 code of exactly the same value. Every binary16 value can be represented in binary32, so the block never rounds. A valid strobe travels with the data. The result and its strobe appear one clock after the input is presented.

All input classes are supported. Normal values are re-biased. Infinities stay infinities. NaNs keep their quiet bit and payload, moved to the top of the wider fraction. Signed zeros keep their sign. Subnormals become normal binary32 values. A leading-zero count over the input fraction gives both the normalising shift and the new exponent. The block raises no exception flags and treats signalling NaNs like any other NaN.

A typical use is on the load path of a unit that stores data in half precision and computes in single precision. The caller presents one code per cycle with the strobe high and collects the widened code one cycle later.

Top module: `hs_widen`

## Requirements
- R1: `outValid` equals `inValid` from the previous clock. While `rstN` is low, `outValid` and `outSingle` are 0.
- R2: For an input whose exponent field (bits 14:10) is 1 to 30, the output exponent field (bits 30:23) is the input exponent plus 112. Bits 22:13 equal input bits 9:0, and bits 12:0 are zero.
- R3: For an input exponent field of 31, the output exponent field is 255. Bits 22:13 equal input bits 9:0, so the quiet bit moves from bit 9 to bit 22 and the rest of the payload follows it. Bits 12:0 are zero, so an infinity input gives an infinity output.
- R4: An input whose bits 14:0 are all zero gives an output whose bits 30:0 are all zero.
- R5: For an input with exponent field 0 and a nonzero fraction, let z be the number of leading zeros of the 10-bit fraction (0 to 9). The output exponent field is 112 − z. Bits 22:13 hold the input fraction shifted left by z+1, keeping only its low 10 bits, so the leading one is dropped. Bits 12:0 are zero.
- R6: Output bit 31 equals input bit 15 for every input class.
- R7: In a cycle where `inValid` is low, `outSingle` keeps its previous value.
- R8: For every non-NaN input, narrowing the output back to binary16 reproduces the original input code exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The input code is present this cycle |
| inHalf | input | 16 | binary16 code |
| outValid | output | 1 | `outSingle` holds a fresh result |
| outSingle | output | 32 | binary32 code of the same value |

## Verification
The bench builds the block with its default widths: a 5-bit exponent and 10-bit fraction in, and an 8-bit exponent and 23-bit fraction out. These are the only widths for which a full input sweep is practical. At those widths it presents all 65,536 input codes, which covers every leading-zero count from 0 to 9, both signs of every class and every NaN payload. Idle cycles are inserted at regular intervals to show that the output holds. The bench also narrows every non-NaN result back to binary16 with its own model, which closes the loop on exactness.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic validNext;  // value outValid takes at the next edge
  } hsStrobe_t;

  // Input class decoded from the exponent and fraction fields
  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_SUB  = 2'd1,
    CL_NORM = 2'd2,
    CL_SPEC = 2'd3
  } hsClass_t;

endpackage

// File: rtl/hs_lzc.sv
module hs_lzc #(
  parameter int WIDTH = 10,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count
);

  // Scans from the LSB upward, so the highest set bit decides the count.
  always_comb begin
    count = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) count = CNT_W'(WIDTH - 1 - i);
    end
  end

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output hsStrobe_t strobe,
  output logic      outValid
);

  always_comb begin
    strobe.load      = inValid;
    strobe.validNext = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.validNext;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int EXP_IN   = 5,
  parameter int FRAC_IN  = 10,
  parameter int EXP_OUT  = 8,
  parameter int FRAC_OUT = 23,
  localparam int IN_W    = 1 + EXP_IN + FRAC_IN,
  localparam int OUT_W   = 1 + EXP_OUT + FRAC_OUT
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobe_t        strobe,
  input  logic [IN_W-1:0]  inWord,
  output logic [OUT_W-1:0] outWord
);

  localparam int IN_BIAS   = (1 << (EXP_IN - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (EXP_OUT - 1)) - 1;
  localparam int BIAS_DIFF = OUT_BIAS - IN_BIAS;
  localparam int SHIFT     = FRAC_OUT - FRAC_IN;
  localparam int LZ_W      = $clog2(FRAC_IN + 1);

  logic               signBit;
  logic [EXP_IN-1:0]  expIn;
  logic [FRAC_IN-1:0] fracIn;
  hsClass_t           cls;
  logic [LZ_W-1:0]    lzCount;
  logic [LZ_W:0]      shAmt;
  logic [FRAC_IN-1:0] normFrac;
  logic [EXP_OUT-1:0] expOut;
  logic [FRAC_IN-1:0] fracOut;
  logic [OUT_W-1:0]   nextWord;

  assign signBit = inWord[IN_W-1];
  assign expIn   = inWord[IN_W-2 -: EXP_IN];
  assign fracIn  = inWord[FRAC_IN-1:0];

  always_comb begin
    if (&expIn)                   cls = CL_SPEC;
    else if (expIn != '0)         cls = CL_NORM;
    else if (fracIn != '0)        cls = CL_SUB;
    else                          cls = CL_ZERO;
  end

  hs_lzc #(.WIDTH(FRAC_IN), .CNT_W(LZ_W)) u_lzc (
    .vec   (fracIn),
    .count (lzCount)
  );

  // Shift by z+1 pushes the leading one out of the field.
  assign shAmt    = {1'b0, lzCount} + (LZ_W+1)'(1);
  assign normFrac = FRAC_IN'(fracIn << shAmt);

  always_comb begin
    unique case (cls)
      CL_NORM: begin
        expOut  = EXP_OUT'(expIn) + EXP_OUT'(BIAS_DIFF);
        fracOut = fracIn;
      end
      CL_SPEC: begin
        expOut  = '1;
        fracOut = fracIn;
      end
      CL_SUB: begin
        expOut  = EXP_OUT'(BIAS_DIFF) - EXP_OUT'(lzCount);
        fracOut = normFrac;
      end
      default: begin
        expOut  = '0;
        fracOut = '0;
      end
    endcase
    nextWord = {signBit, expOut, fracOut, {SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outWord <= '0;
    else if (strobe.load) outWord <= nextWord;
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outWord));
  // R6
  sign_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outWord[OUT_W-1] == $past(inWord[IN_W-1]));
  // R3
  special_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (&inWord[IN_W-2 -: EXP_IN])) |=>
      ((&outWord[OUT_W-2 -: EXP_OUT]) &&
       outWord[FRAC_OUT-1 -: FRAC_IN] == $past(inWord[FRAC_IN-1:0])));
  // R2
  normal_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inWord[IN_W-2 -: EXP_IN] != '0 && !(&inWord[IN_W-2 -: EXP_IN]))
      |=> outWord[SHIFT-1:0] == '0);
  // R4
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inWord[IN_W-2:0] == '0) |=> outWord[OUT_W-2:0] == '0);
  // R5
  sub_exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inWord[IN_W-2 -: EXP_IN] == '0 && inWord[FRAC_IN-1:0] != '0) |=>
      (outWord[OUT_W-2 -: EXP_OUT] <= EXP_OUT'(BIAS_DIFF) &&
       outWord[OUT_W-2 -: EXP_OUT] >  EXP_OUT'(BIAS_DIFF - FRAC_IN)));

endmodule

// File: rtl/hs_widen.sv
module hs_widen
  import hs_pkg::*;
#(
  parameter int EXP_IN   = 5,
  parameter int FRAC_IN  = 10,
  parameter int EXP_OUT  = 8,
  parameter int FRAC_OUT = 23,
  localparam int IN_W    = 1 + EXP_IN + FRAC_IN,
  localparam int OUT_W   = 1 + EXP_OUT + FRAC_OUT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inHalf,
  output logic             outValid,
  output logic [OUT_W-1:0] outSingle
);

  hsStrobe_t strobe;

  hs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hs_datapath #(
    .EXP_IN   (EXP_IN),
    .FRAC_IN  (FRAC_IN),
    .EXP_OUT  (EXP_OUT),
    .FRAC_OUT (FRAC_OUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inWord  (inHalf),
    .outWord (outSingle)
  );

endmodule

// File: tb/hs_widen_tb.sv
`timescale 1ns/1ps
module hs_widen_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] inHalf;
  logic        outValid;
  logic [31:0] outSingle;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hs_widen u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inHalf    (inHalf),
    .outValid  (outValid),
    .outSingle (outSingle)
  );

  // Value-based reference: normalise by repeated doubling.
  function automatic logic [31:0] refWiden(input logic [15:0] h);
    int e;
    int m;
    int ex;
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31) return {h[15], 8'hFF, h[9:0], 13'd0};
    if (e == 0 && m == 0) return {h[15], 31'd0};
    if (e == 0) begin
      ex = -14;
      while (m < 1024) begin
        m  = m * 2;
        ex = ex - 1;
      end
      return {h[15], 8'(ex + 127), 10'(m - 1024), 13'd0};
    end
    return {h[15], 8'(e - 15 + 127), h[9:0], 13'd0};
  endfunction

  // Exact narrowing of a value known to fit in binary16.
  function automatic logic [15:0] refNarrow(input logic [31:0] w);
    int e;
    int m;
    e = int'(w[30:23]);
    if (e == 255) return {w[31], 5'h1F, w[22:13]};
    if (e == 0)   return {w[31], 15'd0};
    if (e >= 113) return {w[31], 5'(e - 112), w[22:13]};
    m = (1024 + int'(w[22:13])) >> (113 - e);
    return {w[31], 5'd0, 10'(m)};
  endfunction

  function automatic string classTag(input logic [15:0] h);
    if (h[14:10] == 5'h1F) return "R3";
    if (h[14:10] != 5'h00) return "R2";
    if (h[9:0] == 10'd0)   return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] lastOut;

  task automatic step(input bit v, input logic [15:0] h);
    logic [31:0] expW;
    inValid = v;
    inHalf  = h;
    @(negedge clk);
    if (v) begin
      expW = refWiden(h);
      check("R1 valid", 32'(outValid), 32'd1);
      check(classTag(h), outSingle, expW);
      check("R6 sign", 32'(outSingle[31]), 32'(h[15]));
      // R8: round trip for every non-NaN code
      if (!(h[14:10] == 5'h1F && h[9:0] != 10'd0))
        check("R8 roundtrip", 32'(refNarrow(outSingle)), 32'(h));
    end else begin
      check("R1 idle", 32'(outValid), 32'd0);
      check("R7 hold", outSingle, lastOut);
    end
    lastOut = outSingle;
  endtask

  initial begin
    rstN    = 1'b0;
    inValid = 1'b1;
    inHalf  = 16'h3C00;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(outValid), 32'd0);
    check("R1 reset data", outSingle, 32'd0);
    rstN    = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    lastOut = outSingle;
    check("R1 after reset", 32'(outValid), 32'd0);
    // Named corner values
    step(1'b1, 16'h0001);  // smallest subnormal, z=9 (R5)
    check("R5 min sub", lastOut, 32'h33800000);
    step(1'b1, 16'h03FF);  // largest subnormal, z=0 (R5)
    check("R5 max sub", lastOut, 32'h387FC000);
    step(1'b1, 16'h7E01);  // quiet NaN with payload (R3)
    check("R3 nan", lastOut, 32'h7FC02000);
    step(1'b1, 16'hFC00);  // negative infinity (R3)
    check("R3 inf", lastOut, 32'hFF800000);
    step(1'b1, 16'h8000);  // negative zero (R4)
    check("R4 negzero", lastOut, 32'h80000000);
    step(1'b1, 16'h3C00);  // one (R2)
    check("R2 one", lastOut, 32'h3F800000);
    // Full sweep with periodic idle cycles
    for (int c = 0; c < 65536; c++) begin
      step(1'b1, 16'(c));
      if ((c % 7) == 3) step(1'b0, 16'(c ^ 16'h5A5A));
    end
    step(1'b0, 16'h0000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule